// File: doc/BRIEF.md
# Hub Upstream Port Control and Status Register

This block is a single byte-wide register for the upstream port of a USB hub, reached over a simple CPU bus with an address, a write strobe, write data and combinational read data. Software uses two control bits. One forces the "K" line state onto the upstream port to signal a remote wakeup. The other puts the port into suspend. Suspend raises a low-power request toward the transceiver and regulator and stops all hub repeater traffic in both directions.

Two read-only bits report the upstream D+ and D- levels. The raw pins first pass through a synchronizer. While the port is active, the status bits hold the line state captured at the most recent end-of-frame EOF2 sample pulse. While the port is suspended, the bits follow the synchronized lines directly, so software can see a resume or wakeup arrive.

Repeater traffic moves through the block as line-symbol streams with valid/ready handshakes. A symbol is `{D+, D-}`, and the K state is `2'b01`. On a blocked path, `out_valid` is low and `in_ready` is low, so the source stalls and no symbol is lost. On an open path, valid, symbol and ready pass straight through with no storage.

While a forced K is active, the upstream transmit stream presents the K symbol with `root_tx_valid` held high and the symbol constant. The upstream source is stalled by `up_in_ready` low.

Top module: `hub_upstream_ctrl`

## Requirements
- R1: Reset clears the resume-force bit (bit 4) and the suspend bit (bit 3). After reset the K drive and the low-power request are off. The D+/D- status bits have no defined value after reset.
- R2: The register answers only at address `REG_ADDR`. Reads of any other address return 0, and writes to any other address leave the register unchanged.
- R3: At the register address, read data is `{3'b000, resume, suspend, 1'b0, D+, D-}`. Writes to bits 7, 6, 5, 2, 1 and 0 have no effect.
- R4: While the resume-force bit is 1, `root_tx_valid` is 1 and `root_tx_sym` is the K symbol `2'b01`.
- R5: The K drive takes priority over upstream repeater traffic and over suspend. While the resume-force bit is 1, `up_in_ready` is 0 whatever the suspend bit is.
- R6: `lp_req` equals the suspend bit.
- R7: While the suspend bit is 1 and the resume-force bit is 0, both repeater paths are blocked. `root_tx_valid`, `up_in_ready`, `dn_out_valid` and `dn_in_ready` are all 0.
- R8: While the suspend bit is 0, the status bits hold the synchronized line state sampled on the clock edge where `eof2_pulse` is 1. Line changes between pulses do not alter them.
- R9: While the suspend bit is 1, the status bits follow `dp_raw`/`dm_raw` with a latency of `SYNC_STAGES` (default 2) clock edges.
- R10: With both control bits 0, each repeater path forwards valid and symbol downstream and ready upstream combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | CPU bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed location |
| eof2_pulse | input | 1 | One-cycle marker of the EOF2 sample instant |
| dp_raw | input | 1 | Asynchronous upstream D+ level |
| dm_raw | input | 1 | Asynchronous upstream D- level |
| lp_req | output | 1 | Low-power request to transceiver and regulator |
| up_in_valid | input | 1 | Upstream-bound repeater symbol valid |
| up_in_sym | input | 2 | Upstream-bound repeater symbol {D+,D-} |
| up_in_ready | output | 1 | Upstream-bound repeater ready |
| root_tx_valid | output | 1 | Upstream port transmit valid |
| root_tx_sym | output | 2 | Upstream port transmit symbol |
| root_tx_ready | input | 1 | Upstream port transmit ready |
| dn_in_valid | input | 1 | Downstream-bound symbol valid |
| dn_in_sym | input | 2 | Downstream-bound symbol |
| dn_in_ready | output | 1 | Downstream-bound ready |
| dn_out_valid | output | 1 | Downstream port transmit valid |
| dn_out_sym | output | 2 | Downstream port transmit symbol |
| dn_out_ready | input | 1 | Downstream port transmit ready |

## Verification
The bench goes after the status bits' two viewing modes. It changes the lines between EOF2 pulses while the port is active. A design that showed live values there would report the new level before the next pulse. It also changes the lines while suspended and samples one edge early and at the stated latency, which exposes a missing or extra synchronizer stage.

It forces K while suspended and while upstream traffic is pending. A design that let suspend or the repeater win would drop `root_tx_valid` or pass the repeater symbol through.

Writes of all ones, and writes to a neighbouring address, catch decoders that let read-only bits or foreign addresses leak into the register.

// File: rtl/hub_rp_pkg.sv
package hub_rp_pkg;
  localparam int REG_W      = 8;
  localparam int SYM_W      = 2;
  localparam int BIT_RESUME = 4;
  localparam int BIT_SUSP   = 3;
  localparam int BIT_DP     = 1;
  localparam int BIT_DM     = 0;

  typedef logic [SYM_W-1:0] line_sym_t;  // {D+, D-}

  localparam line_sym_t SYM_K = 2'b01;
endpackage

// File: rtl/hub_rp_regs.sv
module hub_rp_regs
  import hub_rp_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h5E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              st_dp_i,
  input  logic              st_dm_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              resume_o,
  output logic              susp_o
);
  logic hit;
  logic resume_q, susp_q;
  logic unused_wbits;

  assign hit          = (addr_i == REG_ADDR);
  assign unused_wbits = ^{wdata_i[REG_W-1:BIT_RESUME+1], wdata_i[BIT_SUSP-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resume_q <= 1'b0;
      susp_q   <= 1'b0;
    end else if (wr_i && hit) begin
      resume_q <= wdata_i[BIT_RESUME];
      susp_q   <= wdata_i[BIT_SUSP];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      rdata_o[BIT_RESUME] = resume_q;
      rdata_o[BIT_SUSP]   = susp_q;
      rdata_o[BIT_DP]     = st_dp_i;
      rdata_o[BIT_DM]     = st_dm_i;
    end
  end

  assign resume_o = resume_q;
  assign susp_o   = susp_q;

  // Foreign-address writes leave the register untouched
  assert_foreign_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !hit) |=> ($stable(resume_q) && $stable(susp_q)));
endmodule

// File: rtl/hub_rp_linesamp.sv
module hub_rp_linesamp
  import hub_rp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dp_raw_i,
  input  logic dm_raw_i,
  input  logic eof2_i,
  input  logic susp_i,
  output logic st_dp_o,
  output logic st_dm_o
);
  localparam int LAST = SYNC_STAGES - 1;

  line_sym_t sync_q [SYNC_STAGES];
  line_sym_t latch_q;
  line_sym_t shown;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= '0;
          else        sync_q[0] <= {dp_raw_i, dm_raw_i};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= '0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      latch_q <= '0;
    else if (eof2_i) latch_q <= sync_q[LAST];
  end

  assign shown   = susp_i ? sync_q[LAST] : latch_q;
  assign st_dp_o = shown[1];
  assign st_dm_o = shown[0];

  // Active view only moves on an EOF2 sample
  assert_hold_between_eof2_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!eof2_i && !susp_i) |=> (susp_i || $stable({st_dp_o, st_dm_o})));
endmodule

// File: rtl/hub_rp_gate.sv
module hub_rp_gate
  import hub_rp_pkg::*;
#(
  parameter bit FORCE_EN = 1'b0
) (
  input  logic      blk_i,
  input  logic      force_k_i,
  input  logic      in_valid_i,
  input  line_sym_t in_sym_i,
  output logic      in_ready_o,
  output logic      out_valid_o,
  output line_sym_t out_sym_o,
  input  logic      out_ready_i
);
  logic forcing;

  generate
    if (FORCE_EN) begin : g_force
      assign forcing = force_k_i;
    end else begin : g_noforce
      logic unused_force;
      assign unused_force = force_k_i;
      assign forcing      = 1'b0;
    end
  endgenerate

  always_comb begin
    if (forcing) begin
      out_valid_o = 1'b1;
      out_sym_o   = SYM_K;
      in_ready_o  = 1'b0;
    end else if (blk_i) begin
      out_valid_o = 1'b0;
      out_sym_o   = in_sym_i;
      in_ready_o  = 1'b0;
    end else begin
      out_valid_o = in_valid_i;
      out_sym_o   = in_sym_i;
      in_ready_o  = out_ready_i;
    end
  end
endmodule

// File: rtl/hub_upstream_ctrl.sv
module hub_upstream_ctrl
  import hub_rp_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h5E,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              eof2_pulse,
  input  logic              dp_raw,
  input  logic              dm_raw,
  output logic              lp_req,
  input  logic              up_in_valid,
  input  logic [1:0]        up_in_sym,
  output logic              up_in_ready,
  output logic              root_tx_valid,
  output logic [1:0]        root_tx_sym,
  input  logic              root_tx_ready,
  input  logic              dn_in_valid,
  input  logic [1:0]        dn_in_sym,
  output logic              dn_in_ready,
  output logic              dn_out_valid,
  output logic [1:0]        dn_out_sym,
  input  logic              dn_out_ready
);
  logic resume, susp, st_dp, st_dm;

  hub_rp_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) regs_i (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wr_i(bus_wr),
    .wdata_i(bus_wdata), .st_dp_i(st_dp), .st_dm_i(st_dm),
    .rdata_o(bus_rdata), .resume_o(resume), .susp_o(susp)
  );

  hub_rp_linesamp #(.SYNC_STAGES(SYNC_STAGES)) samp_i (
    .clk(clk), .rst_n(rst_n), .dp_raw_i(dp_raw), .dm_raw_i(dm_raw),
    .eof2_i(eof2_pulse), .susp_i(susp), .st_dp_o(st_dp), .st_dm_o(st_dm)
  );

  hub_rp_gate #(.FORCE_EN(1'b1)) up_gate_i (
    .blk_i(susp), .force_k_i(resume),
    .in_valid_i(up_in_valid), .in_sym_i(up_in_sym), .in_ready_o(up_in_ready),
    .out_valid_o(root_tx_valid), .out_sym_o(root_tx_sym), .out_ready_i(root_tx_ready)
  );

  hub_rp_gate #(.FORCE_EN(1'b0)) dn_gate_i (
    .blk_i(susp), .force_k_i(resume),
    .in_valid_i(dn_in_valid), .in_sym_i(dn_in_sym), .in_ready_o(dn_in_ready),
    .out_valid_o(dn_out_valid), .out_sym_o(dn_out_sym), .out_ready_i(dn_out_ready)
  );

  assign lp_req = susp;

  assert_k_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> (root_tx_valid && root_tx_sym == SYM_K));
  assert_k_stalls_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> !up_in_ready);
  assert_suspend_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    susp |-> (!dn_out_valid && !dn_in_ready && !up_in_ready));
  assert_unimpl_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & 8'hE4) == 8'h00);
endmodule

// File: tb/hub_upstream_ctrl_tb_top.sv
`timescale 1ns/1ps
module hub_upstream_ctrl_tb_top;
  localparam logic [7:0] RA = 8'h5E;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = RA, bus_wdata = '0, bus_rdata;
  logic bus_wr = 1'b0, eof2_pulse = 1'b0, dp_raw = 1'b1, dm_raw = 1'b0, lp_req;
  logic up_in_valid = 1'b0, up_in_ready, root_tx_valid, root_tx_ready = 1'b1;
  logic [1:0] up_in_sym = 2'b00, root_tx_sym, dn_in_sym = 2'b00, dn_out_sym;
  logic dn_in_valid = 1'b0, dn_in_ready, dn_out_valid, dn_out_ready = 1'b1;

  always #4 clk = ~clk;

  hub_upstream_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eof2_pulse(eof2_pulse),
    .dp_raw(dp_raw), .dm_raw(dm_raw), .lp_req(lp_req),
    .up_in_valid(up_in_valid), .up_in_sym(up_in_sym), .up_in_ready(up_in_ready),
    .root_tx_valid(root_tx_valid), .root_tx_sym(root_tx_sym), .root_tx_ready(root_tx_ready),
    .dn_in_valid(dn_in_valid), .dn_in_sym(dn_in_sym), .dn_in_ready(dn_in_ready),
    .dn_out_valid(dn_out_valid), .dn_out_sym(dn_out_sym), .dn_out_ready(dn_out_ready)
  );

  typedef struct {
    bit          ctl;
    logic [15:0] exp;
    logic [15:0] mask;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  event mon_ev;

  // ctl vector: [15]root_tx_valid [14:13]root_tx_sym [12]up_in_ready
  //             [11]dn_out_valid [10:9]dn_out_sym [8]dn_in_ready [7]lp_req
  function automatic logic [15:0] ctl_vec();
    return {root_tx_valid, root_tx_sym, up_in_ready, dn_out_valid, dn_out_sym,
            dn_in_ready, lp_req, 7'b0};
  endfunction

  always @(mon_ev) begin
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it  = q.pop_front();
      act = it.ctl ? ctl_vec() : {8'h00, bus_rdata};
      checks++;
      if ((act & it.mask) !== (it.exp & it.mask)) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h (mask %h)", it.req, act & it.mask,
                 it.exp & it.mask, it.mask);
      end
    end
  end

  task automatic exp_rd(input logic [7:0] a, input logic [7:0] e,
                        input logic [7:0] m, input string req);
    item_t it;
    bus_addr = a;
    it.ctl = 1'b0; it.exp = {8'h00, e}; it.mask = {8'h00, m}; it.req = req;
    q.push_back(it);
    #1 ->mon_ev;
    #1;
  endtask

  task automatic exp_ctl(input logic rv, input logic [1:0] rs, input logic uir,
                         input logic dv, input logic [1:0] ds, input logic dir,
                         input logic lp, input string req);
    item_t it;
    it.ctl  = 1'b1;
    it.exp  = {rv, rs, uir, dv, ds, dir, lp, 7'b0};
    it.mask = {1'b1, {2{rv}}, 1'b1, 1'b1, {2{dv}}, 1'b1, 1'b1, 7'b0};
    it.req  = req;
    q.push_back(it);
    #1 ->mon_ev;
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = RA;
  endtask

  task automatic eof2();
    @(negedge clk); eof2_pulse = 1'b1;
    @(negedge clk); eof2_pulse = 1'b0;
  endtask

  bit done = 1'b0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: control bits clear, no K, no low-power request
    exp_rd(RA, 8'h00, 8'h18, "R1 reset control bits");
    exp_ctl(1'b0, 2'b00, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, "R1 reset outputs");

    // R3: all-ones write touches only bits 4 and 3; lines J (10) long stable
    wr(RA, 8'hFF);
    exp_rd(RA, 8'h1A, 8'hFF, "R3 readback after all-ones write");
    // R4 R5 R6 R7: K beats suspend, lp on, downstream blocked
    exp_ctl(1'b1, 2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, "R4 R5 R6 K under suspend");

    // R2: foreign address
    wr(RA + 8'h01, 8'h00);
    exp_rd(RA, 8'h1A, 8'hFF, "R2 foreign write ignored");
    exp_rd(RA + 8'h01, 8'h00, 8'hFF, "R2 foreign read zero");
    exp_rd(RA - 8'h01, 8'h00, 8'hFF, "R2 lower foreign read zero");
    bus_addr = RA;

    // R9: suspended, live view with SYNC_STAGES latency
    wr(RA, 8'h08);
    exp_ctl(1'b0, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, "R6 R7 suspend only");
    dp_raw = 1'b0; dm_raw = 1'b1;
    @(negedge clk);
    exp_rd(RA, 8'h0A, 8'hFF, "R9 one edge after change still old");
    @(negedge clk);
    exp_rd(RA, 8'h09, 8'hFF, "R9 live after two edges");

    // R8: active view latched at EOF2
    wr(RA, 8'h00);
    eof2();
    exp_rd(RA, 8'h01, 8'hFF, "R8 captured at EOF2");
    dp_raw = 1'b1; dm_raw = 1'b0;
    repeat (5) @(negedge clk);
    exp_rd(RA, 8'h01, 8'hFF, "R8 held between pulses");
    eof2();
    exp_rd(RA, 8'h02, 8'hFF, "R8 new sample at next EOF2");
    dp_raw = 1'b0; dm_raw = 1'b0;
    repeat (3) @(negedge clk);
    exp_rd(RA, 8'h02, 8'hFF, "R8 SE0 not shown before pulse");

    // R10: pass-through with handshakes
    up_in_valid = 1'b1; up_in_sym = 2'b10; root_tx_ready = 1'b0;
    dn_in_valid = 1'b1; dn_in_sym = 2'b01; dn_out_ready = 1'b1;
    #1;
    exp_ctl(1'b1, 2'b10, 1'b0, 1'b1, 2'b01, 1'b1, 1'b0, "R10 back-pressure upstream");
    root_tx_ready = 1'b1; dn_out_ready = 1'b0; dn_in_sym = 2'b11;
    #1;
    exp_ctl(1'b1, 2'b10, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0, "R10 back-pressure downstream");
    dn_out_ready = 1'b1;

    // R5: resume only, upstream traffic pending
    wr(RA, 8'h10);
    exp_ctl(1'b1, 2'b01, 1'b0, 1'b1, 2'b11, 1'b1, 1'b0, "R4 R5 K over traffic");
    exp_rd(RA, 8'h10, 8'h18, "R3 resume bit readback");

    // R7: suspend with traffic
    wr(RA, 8'h08);
    exp_ctl(1'b0, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, "R7 traffic blocked");

    // R1: reset from a set state
    wr(RA, 8'h18);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    exp_rd(RA, 8'h00, 8'h18, "R1 reset clears set bits");
    exp_ctl(1'b1, 2'b10, 1'b1, 1'b1, 2'b11, 1'b1, 1'b0, "R1 R10 outputs after reset");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule